// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Scheduler

This block sits in the command path of an SDRAM controller whose banks are already open. It takes read and write requests, one at a time, over a valid/ready handshake. Each request carries a bank and a column. The block turns each request into a READ or WRITE on a registered command bus, with matching bank and column lines. On every other cycle it drives NOP. It also drives the data mask line (DQM), flags the cycles in which wanted read data is on the bus, and flags the cycle in which the write data path must drive.

The CAS latency can be set to 2 or 3 clocks. The memory masks its read output two clocks after DQM is seen, and a WRITE ends any read burst that is still landing. A write that follows recent reads is therefore held back behind a DQM lead-in. The lead-in ensures that no read data element meets the write data. The DQM mask is high on the cycle just before that WRITE. An optional turnaround mode adds one extra masked cycle, so that at least one idle bus cycle separates the last read data from the write data.

Top module: `sdram_rw_turnaround`

## Requirements
- R1: While reset is high and after it is released, the outputs rest at NOP (`cmd` = 2'b00), `dqm` low, `rd_valid` low, `wr_en` low and `req_ready` high.
- R2: Commands leave in the order the requests were accepted, with the request's bank on `ba` and column on `addr`. A read, or a write with no conflict, is driven in the cycle right after its accepting clock edge, so back-to-back reads issue on consecutive cycles.
- R3: The command encoding is 2'b00 NOP, 2'b01 READ and 2'b10 WRITE. NOP is driven in every cycle without a READ or WRITE, and 2'b11 never appears.
- R4: `rd_valid` is high exactly CL cycles after each READ whose data element is neither masked nor truncated. CL is 3 when `cas_lat3` is 1 and 2 otherwise.
- R5: A write conflicts when a READ was driven in one of the CL+G cycles before the cycle in which the write would otherwise issue. G is 1 when `turn_gap` is 1 and 0 otherwise. With G = 0, a conflicting write gets two `dqm`-high NOP cycles, and the WRITE follows in the third cycle.
- R6: With `turn_gap` = 1, a conflicting write gets three `dqm`-high NOP cycles before the WRITE. Read data is then never valid in the cycle just before the WRITE.
- R7: A write with no conflict issues at once, with `dqm` left low. This holds even when the last read data lands in the cycle just before the WRITE.
- R8: Read data is suppressed if it lands two cycles after a `dqm`-high cycle, or in or after the cycle of a later WRITE. `rd_valid` is never high in a WRITE cycle.
- R9: Every WRITE that cuts into read data has `dqm` high in the two cycles before it, including the cycle just before it.
- R10: `wr_en` is high exactly in the cycles that carry a WRITE command.
- R11: `req_ready` is low in every cycle of a DQM lead-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_lat3 | input | 1 | CAS latency select: 1 gives 3 clocks, 0 gives 2 |
| turn_gap | input | 1 | Adds one idle bus cycle before a write that follows reads |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_bank | input | BANK_W | Request bank |
| req_col | input | COL_W | Request column |
| req_ready | output | 1 | Request accepted at the next edge when high together with valid |
| cmd | output | 2 | Command bus: 00 NOP, 01 READ, 10 WRITE |
| ba | output | BANK_W | Bank lines |
| addr | output | COL_W | Column address lines |
| dqm | output | 1 | Data mask line |
| rd_valid | output | 1 | Wanted read data is on the bus this cycle |
| wr_en | output | 1 | Write data must be driven this cycle |

## Verification
Results are counted in clock cycles, with the accepting edge as the reference point. A READ, or a write with no conflict, shows on the command bus in the cycle that edge starts. A write with a conflict shows up two or three cycles later, and `rd_valid` follows its READ by exactly CL cycles. The bench samples at the falling clock edge and keeps a history of command and mask values for each cycle. Each accepted request carries its acceptance cycle through the scoreboard, and every command is checked against that cycle plus the lead-in the rules predict. Each `rd_valid` sample is recomputed from the READ CL cycles earlier, the mask two cycles earlier, and any WRITE in between.

// File: rtl/sdram_ta_pkg.sv
package sdram_ta_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10
  } cmd_e;

  localparam int MAX_CL  = 3;
  localparam int DQM_LAT = 2;
endpackage

// File: rtl/sdram_ta_sched.sv
// Request acceptance, DQM lead-in sequencing and command registers.
module sdram_ta_sched
  import sdram_ta_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int AGE_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cas3,
  input  logic              gap_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  output cmd_e              cmd_q,
  output cmd_e              cmd_n,
  output logic [BANK_W-1:0] ba_q,
  output logic [COL_W-1:0]  col_q,
  output logic              dqm_q,
  output logic              dqm_n,
  output logic              wr_en_q
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic              pend_q, pend_n;
  logic [1:0]        cnt_q, cnt_n;
  logic [BANK_W-1:0] wbank_q, wbank_n, ba_n;
  logic [COL_W-1:0]  wcol_q, wcol_n, col_n;
  logic [AGE_W-1:0]  age_q, age_n, window;
  logic [1:0]        lead_m1;
  logic              wr_en_n;

  // cycles of read data that a write must stay clear of
  assign window  = AGE_W'(2) + AGE_W'(cas3) + AGE_W'(gap_en);
  assign lead_m1 = gap_en ? 2'd2 : 2'd1;
  assign req_ready = !pend_q;

  always_comb begin
    cmd_n   = CMD_NOP;
    dqm_n   = 1'b0;
    wr_en_n = 1'b0;
    ba_n    = ba_q;
    col_n   = col_q;
    pend_n  = pend_q;
    cnt_n   = cnt_q;
    wbank_n = wbank_q;
    wcol_n  = wcol_q;
    if (pend_q) begin
      if (cnt_q != 2'd0) begin
        dqm_n = 1'b1;
        cnt_n = cnt_q - 2'd1;
      end else begin
        cmd_n   = CMD_WR;
        wr_en_n = 1'b1;
        ba_n    = wbank_q;
        col_n   = wcol_q;
        pend_n  = 1'b0;
      end
    end else if (req_valid) begin
      if (!req_write) begin
        cmd_n = CMD_RD;
        ba_n  = req_bank;
        col_n = req_col;
      end else if (age_q < window) begin
        pend_n  = 1'b1;
        cnt_n   = lead_m1;
        dqm_n   = 1'b1;
        wbank_n = req_bank;
        wcol_n  = req_col;
      end else begin
        cmd_n   = CMD_WR;
        wr_en_n = 1'b1;
        ba_n    = req_bank;
        col_n   = req_col;
      end
    end
    if (cmd_n == CMD_RD)     age_n = '0;
    else if (age_q == AGE_MAX) age_n = AGE_MAX;
    else                     age_n = age_q + AGE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= CMD_NOP;
      dqm_q   <= 1'b0;
      wr_en_q <= 1'b0;
      ba_q    <= '0;
      col_q   <= '0;
      pend_q  <= 1'b0;
      cnt_q   <= 2'd0;
      wbank_q <= '0;
      wcol_q  <= '0;
      age_q   <= AGE_MAX;
    end else begin
      cmd_q   <= cmd_n;
      dqm_q   <= dqm_n;
      wr_en_q <= wr_en_n;
      ba_q    <= ba_n;
      col_q   <= col_n;
      pend_q  <= pend_n;
      cnt_q   <= cnt_n;
      wbank_q <= wbank_n;
      wcol_q  <= wcol_n;
      age_q   <= age_n;
    end
  end
endmodule

// File: rtl/sdram_ta_rdtrack.sv
// Tracks read data in flight; bit k of due_q means data lands k cycles from now.
module sdram_ta_rdtrack
  import sdram_ta_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cas3,
  input  cmd_e cmd_n,
  input  logic dqm_n,
  output logic rd_valid
);
  localparam int DUE_W = MAX_CL + 1;

  logic [DUE_W-1:0] due_q, due_n;

  always_comb begin
    due_n = due_q >> 1;
    if (cmd_n == CMD_RD) begin
      if (cas3) due_n[3] = 1'b1;
      else      due_n[2] = 1'b1;
    end
    if (dqm_n) due_n[DQM_LAT] = 1'b0;
    if (cmd_n == CMD_WR) due_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) due_q <= '0;
    else     due_q <= due_n;
  end

  assign rd_valid = due_q[0];
endmodule

// File: rtl/sdram_rw_turnaround.sv
module sdram_rw_turnaround
  import sdram_ta_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cas_lat3,
  input  logic              turn_gap,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  output logic [1:0]        cmd,
  output logic [BANK_W-1:0] ba,
  output logic [COL_W-1:0]  addr,
  output logic              dqm,
  output logic              rd_valid,
  output logic              wr_en
);
  cmd_e cmd_q, cmd_n;
  logic dqm_n;

  sdram_ta_sched #(.BANK_W(BANK_W), .COL_W(COL_W), .AGE_W(3)) u_sched (
    .clk(clk), .rst(rst), .cas3(cas_lat3), .gap_en(turn_gap),
    .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_col(req_col), .req_ready(req_ready),
    .cmd_q(cmd_q), .cmd_n(cmd_n), .ba_q(ba), .col_q(addr),
    .dqm_q(dqm), .dqm_n(dqm_n), .wr_en_q(wr_en)
  );

  sdram_ta_rdtrack u_track (
    .clk(clk), .rst(rst), .cas3(cas_lat3),
    .cmd_n(cmd_n), .dqm_n(dqm_n), .rd_valid(rd_valid)
  );

  assign cmd = cmd_q;
endmodule

// File: rtl/sdram_ta_checker.sv
module sdram_ta_checker (
  input logic       clk,
  input logic       rst,
  input logic       cas3,
  input logic       gap_en,
  input logic       req_ready,
  input logic [1:0] cmd,
  input logic       dqm,
  input logic       rd_valid,
  input logic       wr_en
);
  // cycles from the last READ to the current cycle, saturating
  logic [2:0] chk_age;
  logic [2:0] win;
  assign win = 3'd2 + {2'b00, cas3} + {2'b00, gap_en};

  always_ff @(posedge clk) begin
    if (rst)                 chk_age <= 3'd7;
    else if (cmd == 2'b01)   chk_age <= 3'd1;
    else if (chk_age != 3'd7) chk_age <= chk_age + 3'd1;
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst) cmd != 2'b11); // R3
  AST_RDV_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (cas3 ? ($past(cmd, 3) == 2'b01) : ($past(cmd, 2) == 2'b01))); // R4
  AST_DQM_LEADIN: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b10 && chk_age <= win) |-> ($past(dqm) && $past(dqm, 2))); // R9
  AST_GAP_LEADIN: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b10 && gap_en && chk_age <= win) |-> $past(dqm, 3)); // R6
  AST_NO_RDV_AT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b10) |-> !rd_valid); // R8
  AST_WREN_CMD: assert property (@(posedge clk) disable iff (rst)
    wr_en == (cmd == 2'b10)); // R10
  AST_READY_LEADIN: assert property (@(posedge clk) disable iff (rst)
    dqm |-> !req_ready); // R11
endmodule

bind sdram_rw_turnaround sdram_ta_checker u_chk (
  .clk(clk), .rst(rst), .cas3(cas_lat3), .gap_en(turn_gap),
  .req_ready(req_ready), .cmd(cmd), .dqm(dqm),
  .rd_valid(rd_valid), .wr_en(wr_en)
);

// File: tb/sim_sdram_rw_turnaround.sv
module sim_sdram_rw_turnaround;
  localparam int BW = 2;
  localparam int CW = 10;

  logic clk = 1'b0, rst = 1'b1, cas3 = 1'b0, gap = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic [CW-1:0] req_col = '0;
  logic req_ready, dqm, rd_valid, wr_en;
  logic [1:0] cmd;
  logic [BW-1:0] ba;
  logic [CW-1:0] addr;

  sdram_rw_turnaround #(.BANK_W(BW), .COL_W(CW)) u0 (
    .clk(clk), .rst(rst), .cas_lat3(cas3), .turn_gap(gap),
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
    .req_col(req_col), .req_ready(req_ready), .cmd(cmd), .ba(ba),
    .addr(addr), .dqm(dqm), .rd_valid(rd_valid), .wr_en(wr_en)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit w; int b; int c; int acc; } item_t;
  item_t sb[$];
  logic [1:0] cmdh [4096];
  logic dqmh [4096];
  logic rvh [4096];
  int errs = 0, checks = 0, rv_cnt = 0;
  int last_rd = -100, last_wr = -100;
  bit done = 0;

  initial for (int i = 0; i < 4096; i++) begin cmdh[i] = 2'b00; dqmh[i] = 1'b0; rvh[i] = 1'b0; end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(bit w, int b, int c);
    item_t it;
    req_valid = 1'b1; req_write = w; req_bank = b[BW-1:0]; req_col = c[CW-1:0];
    while (!req_ready) @(negedge clk);
    it.w = w; it.b = b; it.c = c; it.acc = cyc + 1;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items and recomputes read-data validity per cycle
  always @(negedge clk) begin : mon
    int t, cl, g, lead;
    bit ev, conflict, ok;
    item_t e;
    if (!rst) begin
      t = cyc; cl = cas3 ? 3 : 2; g = gap ? 1 : 0; lead = 2 + g;
      cmdh[t % 4096] = cmd; dqmh[t % 4096] = dqm; rvh[t % 4096] = rd_valid;
      if (rd_valid) rv_cnt++;
      chk(wr_en == (cmd == 2'b10), "R10", wr_en, cmd == 2'b10);
      chk(cmd != 2'b11, "R3", cmd, 0);
      if (dqm) chk(!req_ready, "R11", req_ready, 0);
      if (t >= 8) begin
        ev = (cmdh[(t - cl) % 4096] == 2'b01) && !dqmh[(t - 2) % 4096];
        for (int k = t - cl + 1; k <= t; k++) if (cmdh[k % 4096] == 2'b10) ev = 1'b0;
        chk(rd_valid == ev, "R4 R8 rd_valid", rd_valid, ev);
      end
      if (cmd == 2'b01 || cmd == 2'b10) begin
        if (sb.size() == 0) chk(1'b0, "R2 unexpected command", cmd, 0);
        else begin
          e = sb.pop_front();
          ok = (e.w == (cmd == 2'b10)) && (e.b == int'(ba)) && (e.c == int'(addr));
          chk(ok, "R2 order/bank/column", {cmd, ba, addr}, {(e.w ? 2'b10 : 2'b01), e.b[BW-1:0], e.c[CW-1:0]});
          if (cmd == 2'b01) begin
            chk(t == e.acc, "R2 read issue cycle", t, e.acc);
            last_rd = t;
          end else begin
            conflict = 1'b0;
            for (int r = e.acc - cl - g; r < e.acc; r++)
              if (r >= 0 && cmdh[r % 4096] == 2'b01) conflict = 1'b1;
            if (conflict) begin
              chk(t == e.acc + lead, "R5 lead-in write cycle", t, e.acc + lead);
              chk(dqmh[(t - 1) % 4096] && dqmh[(t - 2) % 4096], "R9 dqm before write", dqmh[(t - 1) % 4096], 1);
              if (g == 1) begin
                chk(dqmh[(t - 3) % 4096], "R6 third dqm cycle", dqmh[(t - 3) % 4096], 1);
                chk(!rvh[(t - 1) % 4096], "R6 idle cycle before write", rvh[(t - 1) % 4096], 0);
              end
            end else begin
              chk(t == e.acc, "R7 immediate write", t, e.acc);
              chk(!dqm, "R7 no dqm", dqm, 0);
            end
            chk(!rd_valid, "R8 no data at write", rd_valid, 0);
            last_wr = t;
          end
        end
      end
    end
  end

  initial begin
    wait (cyc >= 20000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd == 2'b00 && dqm == 1'b0, "R1 reset cmd/dqm", {cmd, dqm}, 0);
    chk(rd_valid == 1'b0 && wr_en == 1'b0, "R1 reset flags", {rd_valid, wr_en}, 0);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    rst = 1'b0;
    idle(9);
    chk(cmd == 2'b00 && !dqm && !rd_valid && !wr_en, "R1 idle after reset", {cmd, dqm, rd_valid, wr_en}, 0);

    // back-to-back reads, CL2
    rv_cnt = 0;
    send(0, 0, 5); send(0, 1, 6); send(0, 2, 7); send(0, 3, 8);
    idle(6);
    chk(rv_cnt == 4, "R4 four read pulses", rv_cnt, 4);

    // read then write at once, CL2, no gap
    rv_cnt = 0;
    send(0, 1, 20); send(1, 2, 21); idle(8);
    chk(last_wr - last_rd == 3, "R5 write spacing", last_wr - last_rd, 3);
    chk(rv_cnt == 1, "R8 read kept before write", rv_cnt, 1);

    // boundary: write lands right after last data, no lead-in
    rv_cnt = 0;
    send(0, 0, 30); idle(2); send(1, 0, 31); idle(8);
    chk(last_wr - last_rd == 3, "R7 adjacent write", last_wr - last_rd, 3);
    chk(rv_cnt == 1, "R7 data before adjacent write", rv_cnt, 1);

    // one cycle earlier: lead-in needed
    send(0, 0, 40); idle(1); send(1, 0, 41); idle(8);
    chk(last_wr - last_rd == 4, "R5 write spacing after gap", last_wr - last_rd, 4);

    // turnaround gap mode
    gap = 1'b1; idle(4);
    rv_cnt = 0;
    send(0, 2, 50); send(1, 3, 51); idle(8);
    chk(last_wr - last_rd == 4, "R6 gap spacing", last_wr - last_rd, 4);
    chk(rv_cnt == 1, "R6 data kept", rv_cnt, 1);
    send(0, 1, 52); idle(3); send(1, 1, 53); idle(8);
    chk(last_wr - last_rd == 4, "R7 gap mode no conflict", last_wr - last_rd, 4);
    send(0, 1, 54); idle(2); send(1, 1, 55); idle(8);
    chk(last_wr - last_rd == 6, "R6 gap boundary", last_wr - last_rd, 6);

    // CL3: write truncates the only read
    gap = 1'b0; cas3 = 1'b1; idle(4);
    rv_cnt = 0;
    send(0, 1, 60); send(1, 1, 61); idle(8);
    chk(last_wr - last_rd == 3, "R5 CL3 spacing", last_wr - last_rd, 3);
    chk(rv_cnt == 0, "R8 truncated read", rv_cnt, 0);

    // CL3: read burst cut by a write
    rv_cnt = 0;
    send(0, 0, 62); send(0, 1, 63); send(0, 2, 64); send(1, 3, 65); idle(8);
    chk(last_wr - last_rd == 3, "R5 burst cut spacing", last_wr - last_rd, 3);
    chk(rv_cnt == 2, "R8 burst partly kept", rv_cnt, 2);

    // writes after long idle, then a read
    idle(10);
    rv_cnt = 0;
    send(1, 2, 70); send(1, 3, 71); send(0, 0, 72); idle(8);
    chk(rv_cnt == 1, "R4 read after writes", rv_cnt, 1);
    chk(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule